// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual page number into its final page table entry by reading a two-level table out of memory. A caller hands it the page number and the frame that holds the top-level table; the walker forms the address of the top-level entry, reads it, and, if that entry is marked present, uses the frame it names to find and read the second-level entry. The entry that comes back is presented in a form that a translation cache can load directly. An absent entry at either level ends the walk with a fault flag and a bit that says which level was absent.

The block handles one walk at a time. It uses a valid/ready handshake to take requests and to deliver results, and a simple memory port that issues one word read and then waits for its data. The table entries follow one fixed layout, because no software takes part in the walk.

Top module: `ptw_walker`

## Requirements
- R1: Reset is synchronous and active low. After reset `busy`, `mem_req_valid` and `rsp_valid` are 0 and `req_ready` is 1.
- R2: The first read of a walk goes to the address {`req_root_frame`, top index, 2'b00}. The top index is bits 19:10 of the 20-bit page number.
- R3: The second read goes to the address {entry[31:12], leaf index, 2'b00}. Here entry is the top-level word just read and the leaf index is page number bits 9:0.
- R4: Bit 0 of an entry is its present bit. When both entries are present, the result carries the second-level word unchanged in `rsp_pte`, with `rsp_fault` = 0 and `rsp_fault_level` = 0.
- R5: When the top-level entry has bit 0 clear, no second read is issued. The result has `rsp_fault` = 1 and `rsp_fault_level` = 0, and `rsp_pte` holds the top-level word.
- R6: When the second-level entry has bit 0 clear, the result has `rsp_fault` = 1 and `rsp_fault_level` = 1, and `rsp_pte` holds that word.
- R7: `busy` is 1 from the cycle after a request is accepted until the cycle after the result is taken. While busy, `req_ready` is 0 and requests are ignored. A request offered in the cycle the result is taken is accepted one cycle later.
- R8: While `rsp_valid` = 1 and `rsp_ready` = 0, the result fields and `rsp_vpn` stay unchanged.
- R9: While `mem_req_valid` = 1 and `mem_req_ready` = 0, the read request stays asserted with an unchanged address.
- R10: Only one read is outstanding: no new read is issued while read data is awaited. `rsp_vpn` echoes the page number of the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Walk request offered |
| req_ready | output | 1 | Walker can accept a request |
| req_vpn | input | 20 | Virtual page number to resolve |
| req_root_frame | input | 20 | Frame of the top-level table |
| mem_req_valid | output | 1 | Word read requested |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_ready | output | 1 | Walker is waiting for read data |
| mem_rsp_data | input | 32 | Entry word read from memory |
| rsp_valid | output | 1 | Walk result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_vpn | output | 20 | Page number the result belongs to |
| rsp_pte | output | 32 | Final entry, or the absent entry on a fault |
| rsp_fault | output | 1 | Walk ended on an absent entry |
| rsp_fault_level | output | 1 | 0: top level absent, 1: second level absent |
| busy | output | 1 | A walk is in progress or its result is pending |

## Verification
Two things can happen in the same cycle: the consumer takes a result, and a new walk request arrives. The bench keeps `req_valid` high with a fresh page number while it raises `rsp_ready`, and it also offers requests while a result is being held back. It judges the outcome at the ports. The request must not be taken while the result is pending. It must be taken in the cycle after the result is taken, which shows up as a first read address built from the new page number and an echoed `rsp_vpn` that matches it. The memory side adds random accept and data delays, and every address and result is compared with values the bench computes itself.

// File: rtl/ptw_pkg.sv
// Package: shared definitions for the page table walker.
// Assumes entries keep their present flag at the bit named here.
package ptw_pkg;

    // Walk sequencing states
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_L0_REQ  = 3'd1,
        ST_L0_WAIT = 3'd2,
        ST_L1_REQ  = 3'd3,
        ST_L1_WAIT = 3'd4,
        ST_DONE    = 3'd5
    } walk_state_t;

    // Position of the present flag inside a table entry
    localparam int PRESENT_BIT = 0;

endpackage

// File: rtl/ptw_addr_gen.sv
// Module: ptw_addr_gen
// Forms the byte address of the table entry for the current level: the
// table frame followed by the level's index scaled by four.
// Assumes TOP_W + 2 and LEAF_W + 2 both fit inside OFFSET_W.
module ptw_addr_gen #(
    parameter int TOP_W    = 10,
    parameter int LEAF_W   = 10,
    parameter int OFFSET_W = 12,
    parameter int FRAME_W  = 20,
    localparam int VPN_W   = TOP_W + LEAF_W,
    localparam int ADDR_W  = FRAME_W + OFFSET_W
) (
    input  logic               level,
    input  logic [VPN_W-1:0]   vpn,
    input  logic [FRAME_W-1:0] table_frame,
    output logic [ADDR_W-1:0]  entry_addr
);

    logic [TOP_W+1:0]    top_byte;
    logic [LEAF_W+1:0]   leaf_byte;
    logic [OFFSET_W-1:0] entry_off;

    // Scale each index to a byte offset of a 4-byte entry
    always_comb begin
        top_byte  = {vpn[VPN_W-1:LEAF_W], 2'b00};
        leaf_byte = {vpn[LEAF_W-1:0], 2'b00};
    end

    // Pick the offset for the level being read and attach the frame
    always_comb begin
        entry_off  = level ? OFFSET_W'(leaf_byte) : OFFSET_W'(top_byte);
        entry_addr = {table_frame, entry_off};
    end

endmodule

// File: rtl/ptw_ctrl.sv
// Module: ptw_ctrl
// Sequences a single walk: accept, read the top-level entry, read the
// second-level entry when the first is present, then hold the result.
// Assumes the memory returns exactly one data beat per accepted read.
module ptw_ctrl
    import ptw_pkg::*;
#(
    parameter int VPN_W   = 20,
    parameter int FRAME_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VPN_W-1:0]   req_vpn,
    input  logic [FRAME_W-1:0] req_root_frame,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    input  logic               mem_rsp_valid,
    output logic               mem_rsp_ready,
    input  logic               entry_present,
    input  logic [FRAME_W-1:0] entry_frame,
    output logic               walk_level,
    output logic [VPN_W-1:0]   walk_vpn,
    output logic [FRAME_W-1:0] walk_frame,
    output logic               capture,
    output logic               cap_fault,
    output logic               cap_level,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic               busy
);

    walk_state_t        state_q, state_d;
    logic [VPN_W-1:0]   vpn_q;
    logic [FRAME_W-1:0] frame_q;
    logic               accept;
    logic               rd_done;

    // Handshake strobes derived from the current state
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_L0_REQ) || (state_q == ST_L1_REQ);
        mem_rsp_ready = (state_q == ST_L0_WAIT) || (state_q == ST_L1_WAIT);
        rsp_valid     = (state_q == ST_DONE);
        busy          = (state_q != ST_IDLE);
        walk_level    = (state_q == ST_L1_REQ) || (state_q == ST_L1_WAIT);
        accept        = req_valid && req_ready;
        rd_done       = mem_rsp_valid && mem_rsp_ready;
    end

    // Decide when the result is final and what it reports
    always_comb begin
        cap_level = (state_q == ST_L1_WAIT);
        cap_fault = !entry_present;
        capture   = rd_done && (cap_level || !entry_present);
    end

    // Next-state logic for the walk sequence
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept) state_d = ST_L0_REQ;
            ST_L0_REQ:  if (mem_req_ready) state_d = ST_L0_WAIT;
            ST_L0_WAIT: if (rd_done) state_d = entry_present ? ST_L1_REQ : ST_DONE;
            ST_L1_REQ:  if (mem_req_ready) state_d = ST_L1_WAIT;
            ST_L1_WAIT: if (rd_done) state_d = ST_DONE;
            ST_DONE:    if (rsp_ready) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Latch the request and swap in the second-level table frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q   <= '0;
            frame_q <= '0;
        end else if (accept) begin
            vpn_q   <= req_vpn;
            frame_q <= req_root_frame;
        end else if (rd_done && !cap_level && entry_present) begin
            frame_q <= entry_frame;
        end
    end

    assign walk_vpn   = vpn_q;
    assign walk_frame = frame_q;

    // R7: no request is taken while a walk or its result is pending
    p_busy_refuses_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

    // R7: an accepted request makes the walker busy in the next cycle
    p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> busy);

    // R9: a stalled read keeps its request and address
    p_read_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(walk_frame) && $stable(walk_level)));

    // R10: never a new read while data is awaited
    p_single_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_ready |-> !mem_req_valid);

    // R5: an absent top-level entry never leads to a second read
    p_no_leaf_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rsp_valid && mem_rsp_ready && !walk_level && !entry_present) |=> !mem_req_valid);

endmodule

// File: rtl/ptw_result.sv
// Module: ptw_result
// Holds the walk outcome for the consumer: the page number, the entry
// word and the fault flags. They stay unchanged until the next capture.
// Assumes capture fires only once per walk, before the result is offered.
module ptw_result
    import ptw_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int PTE_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [VPN_W-1:0] cap_vpn,
    input  logic [PTE_W-1:0] cap_pte,
    input  logic             cap_fault,
    input  logic             cap_level,
    input  logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [VPN_W-1:0] rsp_vpn,
    output logic [PTE_W-1:0] rsp_pte,
    output logic             rsp_fault,
    output logic             rsp_fault_level
);

    // Capture the final entry and its fault classification
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vpn         <= '0;
            rsp_pte         <= '0;
            rsp_fault       <= 1'b0;
            rsp_fault_level <= 1'b0;
        end else if (capture) begin
            rsp_vpn         <= cap_vpn;
            rsp_pte         <= cap_pte;
            rsp_fault       <= cap_fault;
            rsp_fault_level <= cap_fault && cap_level;
        end
    end

    // R8: a result waiting for the consumer does not move
    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pte) && $stable(rsp_vpn)
                                       && $stable(rsp_fault) && $stable(rsp_fault_level)));

    // R4: a successful result carries a present entry
    p_ok_present_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> rsp_pte[PRESENT_BIT]);

    // R5, R6: a faulting result carries an absent entry
    p_fault_absent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> !rsp_pte[PRESENT_BIT]);

endmodule

// File: rtl/ptw_walker.sv
// Module: ptw_walker
// Top of the two-level page table walker. It joins the walk sequencer,
// the entry address former and the result holder.
// Assumes entries hold the frame in their upper bits and the present
// flag in bit PRESENT_BIT.
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int TOP_W    = 10,
    parameter int LEAF_W   = 10,
    parameter int OFFSET_W = 12,
    parameter int PTE_W    = 32,
    localparam int VPN_W   = TOP_W + LEAF_W,
    localparam int FRAME_W = PTE_W - OFFSET_W,
    localparam int ADDR_W  = FRAME_W + OFFSET_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VPN_W-1:0]   req_vpn,
    input  logic [FRAME_W-1:0] req_root_frame,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [ADDR_W-1:0]  mem_req_addr,
    input  logic               mem_rsp_valid,
    output logic               mem_rsp_ready,
    input  logic [PTE_W-1:0]   mem_rsp_data,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [VPN_W-1:0]   rsp_vpn,
    output logic [PTE_W-1:0]   rsp_pte,
    output logic               rsp_fault,
    output logic               rsp_fault_level,
    output logic               busy
);

    logic               walk_level;
    logic [VPN_W-1:0]   walk_vpn;
    logic [FRAME_W-1:0] walk_frame;
    logic               capture;
    logic               cap_fault;
    logic               cap_level;

    ptw_ctrl #(
        .VPN_W   (VPN_W),
        .FRAME_W (FRAME_W)
    ) i_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_vpn        (req_vpn),
        .req_root_frame (req_root_frame),
        .mem_req_valid  (mem_req_valid),
        .mem_req_ready  (mem_req_ready),
        .mem_rsp_valid  (mem_rsp_valid),
        .mem_rsp_ready  (mem_rsp_ready),
        .entry_present  (mem_rsp_data[PRESENT_BIT]),
        .entry_frame    (mem_rsp_data[PTE_W-1:OFFSET_W]),
        .walk_level     (walk_level),
        .walk_vpn       (walk_vpn),
        .walk_frame     (walk_frame),
        .capture        (capture),
        .cap_fault      (cap_fault),
        .cap_level      (cap_level),
        .rsp_valid      (rsp_valid),
        .rsp_ready      (rsp_ready),
        .busy           (busy)
    );

    ptw_addr_gen #(
        .TOP_W    (TOP_W),
        .LEAF_W   (LEAF_W),
        .OFFSET_W (OFFSET_W),
        .FRAME_W  (FRAME_W)
    ) i_addr (
        .level       (walk_level),
        .vpn         (walk_vpn),
        .table_frame (walk_frame),
        .entry_addr  (mem_req_addr)
    );

    ptw_result #(
        .VPN_W (VPN_W),
        .PTE_W (PTE_W)
    ) i_result (
        .clk             (clk),
        .rst_n           (rst_n),
        .capture         (capture),
        .cap_vpn         (walk_vpn),
        .cap_pte         (mem_rsp_data),
        .cap_fault       (cap_fault),
        .cap_level       (cap_level),
        .rsp_valid       (rsp_valid),
        .rsp_ready       (rsp_ready),
        .rsp_vpn         (rsp_vpn),
        .rsp_pte         (rsp_pte),
        .rsp_fault       (rsp_fault),
        .rsp_fault_level (rsp_fault_level)
    );

    // R2, R3: every entry read is word aligned
    p_aligned_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

    // R10: the result offered belongs to the page number being walked
    p_echo_vpn_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_vpn == walk_vpn));

endmodule

// File: tb/test_ptw_walker.sv
`timescale 1ns/1ps
// Bench for ptw_walker: directed corner walks followed by seeded random
// walks. A bench-side memory responder applies random stalls.
module test_ptw_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_vpn = '0;
    logic [19:0] req_root_frame = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic        mem_rsp_ready;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [19:0] rsp_vpn;
    logic [31:0] rsp_pte;
    logic        rsp_fault;
    logic        rsp_fault_level;
    logic        busy;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ptw_walker i_ptw_walker (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid       (req_valid),
        .req_ready       (req_ready),
        .req_vpn         (req_vpn),
        .req_root_frame  (req_root_frame),
        .mem_req_valid   (mem_req_valid),
        .mem_req_ready   (mem_req_ready),
        .mem_req_addr    (mem_req_addr),
        .mem_rsp_valid   (mem_rsp_valid),
        .mem_rsp_ready   (mem_rsp_ready),
        .mem_rsp_data    (mem_rsp_data),
        .rsp_valid       (rsp_valid),
        .rsp_ready       (rsp_ready),
        .rsp_vpn         (rsp_vpn),
        .rsp_pte         (rsp_pte),
        .rsp_fault       (rsp_fault),
        .rsp_fault_level (rsp_fault_level),
        .busy            (busy)
    );

    // Record one check and report a mismatch
    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected address of the top-level entry
    function automatic logic [31:0] top_addr(input logic [19:0] root, input logic [19:0] vpn);
        return {root, vpn[19:10], 2'b00};
    endfunction

    // Expected address of the second-level entry
    function automatic logic [31:0] leaf_addr(input logic [31:0] top_entry, input logic [19:0] vpn);
        return {top_entry[31:12], vpn[9:0], 2'b00};
    endfunction

    // Build an entry word with the given frame and present flag
    function automatic logic [31:0] make_entry(input logic [19:0] frame, input logic present);
        logic [10:0] mid;
        mid = 11'($urandom);
        return {frame, mid, present};
    endfunction

    // Serve one read: check address, stall, accept, return data
    task automatic serve_read(input logic [31:0] exp_addr, input logic [31:0] data, input string tag);
        int n = 0;
        int stall;
        int lat;
        while (!mem_req_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
        check(mem_req_valid, "R10 read issued", {31'd0, mem_req_valid}, 32'd1);
        check(mem_req_addr == exp_addr, tag, mem_req_addr, exp_addr);
        stall = $urandom % 3;
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            check(mem_req_valid && mem_req_addr == exp_addr, "R9 read held", mem_req_addr, exp_addr);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        check(!mem_req_valid && busy, "R10 no read while waiting", {31'd0, mem_req_valid}, 32'd0);
        lat = $urandom % 3;
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            check(!mem_req_valid, "R10 no read while waiting", {31'd0, mem_req_valid}, 32'd0);
        end
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = data;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = 32'h0;
    endtask

    // Run one complete walk; optionally chain the next request onto the take
    task automatic walk(input logic [19:0] vpn, input logic [19:0] root,
                        input logic p0, input logic p1,
                        input bit chain, input logic [19:0] nvpn, input logic [19:0] nroot);
        logic [31:0] e0, e1, exp_pte;
        logic        exp_fault, exp_lvl;
        int          n = 0;
        int          stall;
        check(req_ready && !busy, "R7 idle before request", {31'd0, req_ready}, 32'd1);
        req_valid      = 1'b1;
        req_vpn        = vpn;
        req_root_frame = root;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy && !req_ready, "R7 busy after accept", {31'd0, busy}, 32'd1);
        e0 = make_entry(20'($urandom), p0);
        serve_read(top_addr(root, vpn), e0, "R2 top-level address");
        if (p0) begin
            e1 = make_entry(20'($urandom), p1);
            serve_read(leaf_addr(e0, vpn), e1, "R3 second-level address");
            exp_pte   = e1;
            exp_fault = !p1;
            exp_lvl   = !p1;
        end else begin
            exp_pte   = e0;
            exp_fault = 1'b1;
            exp_lvl   = 1'b0;
        end
        while (!rsp_valid && n < 50) begin
            if (!p0) check(!mem_req_valid, "R5 no second read", {31'd0, mem_req_valid}, 32'd0);
            @(negedge clk);
            n++;
        end
        if (!p0) check(!mem_req_valid, "R5 no second read", {31'd0, mem_req_valid}, 32'd0);
        check(rsp_valid, "R4 result offered", {31'd0, rsp_valid}, 32'd1);
        check(rsp_pte == exp_pte, exp_fault ? (exp_lvl ? "R6 leaf entry" : "R5 top entry") : "R4 final entry",
              rsp_pte, exp_pte);
        check(rsp_fault == exp_fault, exp_fault ? (exp_lvl ? "R6 fault flag" : "R5 fault flag") : "R4 fault flag",
              {31'd0, rsp_fault}, {31'd0, exp_fault});
        check(rsp_fault_level == exp_lvl, exp_lvl ? "R6 fault level" : "R5 fault level",
              {31'd0, rsp_fault_level}, {31'd0, exp_lvl});
        check(rsp_vpn == vpn, "R10 echoed page number", {12'd0, rsp_vpn}, {12'd0, vpn});
        stall = $urandom % 3;
        for (int i = 0; i < stall; i++) begin
            req_valid      = 1'b1;
            req_vpn        = ~vpn;
            req_root_frame = ~root;
            @(negedge clk);
            check(rsp_valid && rsp_pte == exp_pte && rsp_vpn == vpn && rsp_fault == exp_fault,
                  "R8 result held", rsp_pte, exp_pte);
            check(!req_ready && busy, "R7 request refused while busy", {31'd0, req_ready}, 32'd0);
        end
        rsp_ready = 1'b1;
        req_valid = chain;
        req_vpn        = nvpn;
        req_root_frame = nroot;
        @(negedge clk);
        rsp_ready = 1'b0;
        check(!rsp_valid && !busy && req_ready, "R7 idle after take", {31'd0, busy}, 32'd0);
        if (!chain) req_valid = 1'b0;
    endtask

    // Watchdog: an expired run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Main sequence: reset, directed corners, random walks
    initial begin
        logic [19:0] v, r, nv, nr;
        bit          ch;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check(!busy && req_ready && !mem_req_valid && !rsp_valid, "R1 reset state",
              {28'd0, busy, req_ready, mem_req_valid, rsp_valid}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && req_ready, "R1 idle after reset", {31'd0, req_ready}, 32'd1);

        walk(20'h00000, 20'h00000, 1'b1, 1'b1, 1'b0, '0, '0);   // R4 lowest indices
        walk(20'hFFFFF, 20'hFFFFF, 1'b1, 1'b1, 1'b0, '0, '0);   // R2 R3 highest indices
        walk(20'h12345, 20'h0ABCD, 1'b0, 1'b1, 1'b0, '0, '0);   // R5 top level absent
        walk(20'h54321, 20'h0DCBA, 1'b1, 1'b0, 1'b0, '0, '0);   // R6 leaf absent
        walk(20'hA5A5A, 20'h00F0F, 1'b1, 1'b1, 1'b1, 20'h3C3C3, 20'h11111); // R7 chained
        walk(20'h3C3C3, 20'h11111, 1'b0, 1'b0, 1'b0, '0, '0);

        nv = 20'($urandom);
        nr = 20'($urandom);
        ch = 1'b0;
        for (int k = 0; k < 80; k++) begin
            v  = nv;
            r  = nr;
            nv = 20'($urandom);
            nr = 20'($urandom);
            ch = ($urandom % 3) == 0;
            walk(v, r, ($urandom % 4) != 0, ($urandom % 4) != 0, ch, nv, nr);
        end
        req_valid = 1'b0;
        @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule